// File: doc/BRIEF.md
# Cross-Lane Permute Unit

This block rearranges the lanes of a 64-lane vector. Lanes are grouped into rows of 16. A 9-bit permute code selects the pattern. The patterns are:

- a free choice of source inside each group of four lanes;
- a shift, rotate or mirror inside each row;
- a shift or rotate of the whole wave by one lane;
- a broadcast of the last lane of one group into the next group.

For every destination lane the block works out a source lane. It then fetches that source's value from the input vector as it stood at acceptance, so a lane never sees a value produced by the same operation.

Each lane then takes one of three results: the fetched value, zero, or its previous destination value. Four things decide which: a per-row enable mask, a per-bank enable mask (bank = lane mod 4), the execution mask of the source lane, and a zero-fill bit.

A two-state controller manages the transfer. In `ST_IDLE` the unit raises `in_ready`. An accepted request (`in_valid && in_ready`) takes the *accept* transition to `ST_DONE`, and the registered result is loaded on that same edge. `ST_DONE` shows the result with `out_valid` for exactly one cycle. It then takes the *drain* transition back to `ST_IDLE`. `in_ready` is low in `ST_DONE`, so a request can be accepted at most every second cycle. Reset puts the controller in `ST_IDLE` and clears the output register.

Top module: `lane_permute_unit`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0, `in_ready` is 1, `out_vec` is all zero and `out_illegal` is 0.
- R2: An accepted request makes `out_valid` 1 in the next cycle, for exactly one cycle. `in_ready` is 0 during that cycle and 1 in the cycle after it.
- R3: Codes 0x000–0x0FF are a quad permute. Bits [2i+1:2i] of the code give the position within the quad (0–3) that feeds quad position i, in every quad.
- R4: Codes 0x101–0x10F shift each row left by c = code[3:0]. Row offset k reads offset k+c of the same row, and is out of bounds when k+c > 15.
- R5: Codes 0x111–0x11F shift each row right by c = code[3:0]. Row offset k reads offset k−c, and is out of bounds when k−c < 0.
- R6: Codes 0x121–0x12F rotate each row right by c = code[3:0]. Offset k reads (k−c+16) mod 16 in the same row, and is never out of bounds.
- R7: Whole-wave moves work as follows. 0x130: lane n reads n+1, and lane 63 is out of bounds. 0x134: lane n reads (n+1) mod 64. 0x138: lane n reads n−1, and lane 0 is out of bounds. 0x13C: lane n reads (n+63) mod 64.
- R8: Mirrors work as follows. 0x140: row offset k reads offset 15−k. 0x141: mirrors within each half-row of 8, so offset k reads (k AND 8) + 7 − (k AND 7).
- R9: Broadcasts work as follows. 0x142: lanes 16–63 read lane (n AND 0x30) − 1, and lanes 0–15 are out of bounds. 0x143: lanes 32–63 read lane 31, and lanes 0–31 are out of bounds.
- R10: A lane keeps its previous destination value if `row_mask[n/16]` is 0 or `bank_mask[n mod 4]` is 0.
- R11: An enabled lane whose source is out of bounds, or whose source lane has a 0 in `exec_mask`, is written with zero when `bound_zero` is 1 and keeps its previous value otherwise.
- R12: Code 0x100 and every code not listed in R3–R9 (for example 0x110, 0x120, 0x131, 0x144) set `out_illegal` to 1 and leave every lane at its previous destination value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| perm_ctrl | input | 9 | Permute code |
| row_mask | input | 4 | Per-row write enable |
| bank_mask | input | 4 | Per-bank write enable (bank = lane mod 4) |
| bound_zero | input | 1 | Zero-fill lanes with no usable source |
| exec_mask | input | 64 | Active bit per source lane |
| src_vec | input | 512 | Input vector, lane n at bits [8n+7:8n] |
| old_vec | input | 512 | Previous destination vector, same layout |
| out_valid | output | 1 | Result valid pulse |
| out_illegal | output | 1 | Result came from an unsupported code |
| out_vec | output | 512 | Permuted result, same layout |

## Verification
A wrong source index computed for one lane shows up as a single wrong byte in `out_vec`. It appears in the one cycle where `out_valid` is high after the request. A mistake in the bounds or masking decision shows in the same cycle, as a wrong zero or a wrongly preserved old byte. This is only visible when the source and old patterns differ in every lane, so the bench uses distinct values for the two. A stuck or mis-sequenced controller shows within one cycle of acceptance, as a missing `out_valid` pulse, a pulse longer than one cycle, or `in_ready` not dropping.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

    typedef enum logic [3:0] {
        PM_QUAD,
        PM_ROW_SL,
        PM_ROW_SR,
        PM_ROW_RR,
        PM_WAVE_SL,
        PM_WAVE_RL,
        PM_WAVE_SR,
        PM_WAVE_RR,
        PM_MIRROR,
        PM_HALF_MIRROR,
        PM_BCAST_ROW,
        PM_BCAST_HALF,
        PM_ILLEGAL
    } perm_mode_e;

    typedef struct packed {
        perm_mode_e  mode;
        logic [3:0]  amount;
        logic [7:0]  quad_sel;
    } perm_cmd_t;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_DONE
    } fsm_state_e;

endpackage

// File: rtl/lpu_ctrl_decode.sv
module lpu_ctrl_decode
    import lpu_pkg::*;
(
    input  logic [8:0] ctrl_i,
    output perm_cmd_t  cmd_o
);

    always_comb begin
        cmd_o.amount   = ctrl_i[3:0];
        cmd_o.quad_sel = ctrl_i[7:0];
        cmd_o.mode     = PM_ILLEGAL;
        if (!ctrl_i[8]) begin
            cmd_o.mode = PM_QUAD;
        end else if (ctrl_i[7:4] == 4'h0 && ctrl_i[3:0] != 4'h0) begin
            cmd_o.mode = PM_ROW_SL;
        end else if (ctrl_i[7:4] == 4'h1 && ctrl_i[3:0] != 4'h0) begin
            cmd_o.mode = PM_ROW_SR;
        end else if (ctrl_i[7:4] == 4'h2 && ctrl_i[3:0] != 4'h0) begin
            cmd_o.mode = PM_ROW_RR;
        end else begin
            unique case (ctrl_i[7:0])
                8'h30:   cmd_o.mode = PM_WAVE_SL;
                8'h34:   cmd_o.mode = PM_WAVE_RL;
                8'h38:   cmd_o.mode = PM_WAVE_SR;
                8'h3C:   cmd_o.mode = PM_WAVE_RR;
                8'h40:   cmd_o.mode = PM_MIRROR;
                8'h41:   cmd_o.mode = PM_HALF_MIRROR;
                8'h42:   cmd_o.mode = PM_BCAST_ROW;
                8'h43:   cmd_o.mode = PM_BCAST_HALF;
                default: cmd_o.mode = PM_ILLEGAL;
            endcase
        end
    end

endmodule

// File: rtl/lpu_src_select.sv
module lpu_src_select
    import lpu_pkg::*;
#(
    parameter int LANES     = 64,
    parameter int ROW_LANES = 16,
    parameter int LANE      = 0,
    localparam int LANE_W   = $clog2(LANES)
) (
    input  perm_cmd_t          cmd_i,
    output logic [LANE_W-1:0]  src_o,
    output logic               oob_o
);

    localparam int K         = LANE % ROW_LANES;
    localparam int ROW_BASE  = LANE - K;
    localparam int HALF      = ROW_LANES / 2;
    localparam int HALF_BASE = (K / HALF) * HALF;
    localparam int HK        = K % HALF;
    localparam int WAVE_HALF = LANES / 2;
    localparam int QPOS      = LANE % 4;
    localparam int QBASE     = LANE - QPOS;

    int tgt;

    always_comb begin
        tgt   = LANE;
        oob_o = 1'b0;
        unique case (cmd_i.mode)
            PM_QUAD: tgt = QBASE + int'(cmd_i.quad_sel[2*QPOS +: 2]);
            PM_ROW_SL: begin
                tgt   = K + int'(cmd_i.amount);
                oob_o = (tgt >= ROW_LANES);
                tgt   = oob_o ? LANE : ROW_BASE + tgt;
            end
            PM_ROW_SR: begin
                tgt   = K - int'(cmd_i.amount);
                oob_o = (tgt < 0);
                tgt   = oob_o ? LANE : ROW_BASE + tgt;
            end
            PM_ROW_RR: tgt = ROW_BASE + ((K - int'(cmd_i.amount) + ROW_LANES) % ROW_LANES);
            PM_WAVE_SL: begin
                oob_o = (LANE == LANES - 1);
                tgt   = oob_o ? LANE : LANE + 1;
            end
            PM_WAVE_RL: tgt = (LANE + 1) % LANES;
            PM_WAVE_SR: begin
                oob_o = (LANE == 0);
                tgt   = oob_o ? LANE : LANE - 1;
            end
            PM_WAVE_RR:     tgt = (LANE + LANES - 1) % LANES;
            PM_MIRROR:      tgt = ROW_BASE + ROW_LANES - 1 - K;
            PM_HALF_MIRROR: tgt = ROW_BASE + HALF_BASE + HALF - 1 - HK;
            PM_BCAST_ROW: begin
                oob_o = (LANE < ROW_LANES);
                tgt   = oob_o ? LANE : ROW_BASE - 1;
            end
            PM_BCAST_HALF: begin
                oob_o = (LANE < WAVE_HALF);
                tgt   = oob_o ? LANE : WAVE_HALF - 1;
            end
            default: tgt = LANE;
        endcase
        src_o = LANE_W'(tgt);
    end

endmodule

// File: rtl/lpu_lane_merge.sv
module lpu_lane_merge #(
    parameter int DATA_W = 8
) (
    input  logic              lane_on_i,
    input  logic              src_live_i,
    input  logic              bound_zero_i,
    input  logic              illegal_i,
    input  logic [DATA_W-1:0] new_i,
    input  logic [DATA_W-1:0] old_i,
    output logic [DATA_W-1:0] val_o
);

    always_comb begin
        if (illegal_i || !lane_on_i) begin
            val_o = old_i;
        end else if (src_live_i) begin
            val_o = new_i;
        end else if (bound_zero_i) begin
            val_o = '0;
        end else begin
            val_o = old_i;
        end
    end

endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
    import lpu_pkg::*;
#(
    parameter int LANES     = 64,
    parameter int ROW_LANES = 16,
    parameter int DATA_W    = 8,
    localparam int ROWS     = LANES / ROW_LANES,
    localparam int BANKS    = 4,
    localparam int LANE_W   = $clog2(LANES),
    localparam int VEC_W    = LANES * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [8:0]         perm_ctrl,
    input  logic [ROWS-1:0]    row_mask,
    input  logic [BANKS-1:0]   bank_mask,
    input  logic               bound_zero,
    input  logic [LANES-1:0]   exec_mask,
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W-1:0]   old_vec,
    output logic               out_valid,
    output logic               out_illegal,
    output logic [VEC_W-1:0]   out_vec
);

    fsm_state_e state_q, state_d;
    perm_cmd_t  cmd;
    logic       accept;
    logic       illegal;

    logic [LANE_W-1:0] src_idx [LANES];
    logic [LANES-1:0]  oob_vec;
    logic [LANES-1:0]  lane_on;
    logic [VEC_W-1:0]  lane_res;
    logic [VEC_W-1:0]  out_vec_q;
    logic              out_illegal_q;

    lpu_ctrl_decode u_decode (
        .ctrl_i (perm_ctrl),
        .cmd_o  (cmd)
    );

    assign illegal = (cmd.mode == PM_ILLEGAL);

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [DATA_W-1:0] gathered;
        logic              src_live;

        lpu_src_select #(
            .LANES     (LANES),
            .ROW_LANES (ROW_LANES),
            .LANE      (L)
        ) u_sel (
            .cmd_i (cmd),
            .src_o (src_idx[L]),
            .oob_o (oob_vec[L])
        );

        assign gathered   = src_vec[int'(src_idx[L]) * DATA_W +: DATA_W];
        assign src_live   = !oob_vec[L] && exec_mask[src_idx[L]];
        assign lane_on[L] = row_mask[L / ROW_LANES] && bank_mask[L % BANKS];

        lpu_lane_merge #(.DATA_W(DATA_W)) u_merge (
            .lane_on_i    (lane_on[L]),
            .src_live_i   (src_live),
            .bound_zero_i (bound_zero),
            .illegal_i    (illegal),
            .new_i        (gathered),
            .old_i        (old_vec[L*DATA_W +: DATA_W]),
            .val_o        (lane_res[L*DATA_W +: DATA_W])
        );

        // row-local modes never leave the lane's own row (R4, R5)
        p_row_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmd.mode == PM_ROW_SL || cmd.mode == PM_ROW_SR || cmd.mode == PM_ROW_RR
              || cmd.mode == PM_MIRROR || cmd.mode == PM_HALF_MIRROR) && !oob_vec[L])
            |-> ((int'(src_idx[L]) / ROW_LANES) == (L / ROW_LANES)));

        p_rotate_inbounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd.mode == PM_ROW_RR || cmd.mode == PM_WAVE_RL || cmd.mode == PM_WAVE_RR
             || cmd.mode == PM_QUAD) |-> !oob_vec[L]);

        p_masked_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && !lane_on[L])
            |=> (out_vec[L*DATA_W +: DATA_W] == $past(old_vec[L*DATA_W +: DATA_W])));
    end

    assign accept = in_valid && in_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: accept moves to done, drain returns to idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // controller outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_DONE: out_valid = 1'b1;
            default: in_ready  = 1'b0;
        endcase
    end

    // result register, loaded on the accept edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vec_q     <= '0;
            out_illegal_q <= 1'b0;
        end else if (accept) begin
            out_vec_q     <= lane_res;
            out_illegal_q <= illegal;
        end
    end

    assign out_vec     = out_vec_q;
    assign out_illegal = out_illegal_q;

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    p_accept_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_reserved_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && perm_ctrl == 9'h100) |=> out_illegal);

endmodule

// File: tb/lane_permute_unit_tb_top.sv
module lane_permute_unit_tb_top;

    localparam int LANES  = 64;
    localparam int DW     = 8;
    localparam int VEC_W  = LANES * DW;
    localparam int NVEC   = 21;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [8:0]       perm_ctrl = '0;
    logic [3:0]       row_mask = '0;
    logic [3:0]       bank_mask = '0;
    logic             bound_zero = 1'b0;
    logic [LANES-1:0] exec_mask = '0;
    logic [VEC_W-1:0] src_vec = '0;
    logic [VEC_W-1:0] old_vec = '0;
    logic             out_valid;
    logic             out_illegal;
    logic [VEC_W-1:0] out_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    lane_permute_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .perm_ctrl   (perm_ctrl),
        .row_mask    (row_mask),
        .bank_mask   (bank_mask),
        .bound_zero  (bound_zero),
        .exec_mask   (exec_mask),
        .src_vec     (src_vec),
        .old_vec     (old_vec),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_vec     (out_vec)
    );

    // {ctrl, row_mask, bank_mask, bound_zero, exec_mask}
    localparam logic [81:0] TBL [NVEC] = '{
        {9'h0E4, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h01B, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h000, 4'hF, 4'hF, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h101, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h10F, 4'hF, 4'hF, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h113, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h125, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h130, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h134, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h138, 4'hF, 4'hF, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h13C, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h140, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h141, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h142, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h143, 4'hF, 4'hF, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h0E4, 4'h5, 4'hA, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h101, 4'hF, 4'hF, 1'b1, 64'hF0F0_F0F0_0F0F_0F0F},
        {9'h130, 4'hF, 4'hF, 1'b0, 64'h5555_AAAA_3333_CCCC},
        {9'h100, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h144, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {9'h110, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF}
    };

    function automatic string req_of(logic [81:0] e);
        logic [8:0] c = e[81:73];
        if (e[72:65] != 8'hFF)                 return "R10";
        if (e[63:0] != '1)                     return "R11";
        if (c <= 9'h0FF)                       return "R3";
        if (c >= 9'h101 && c <= 9'h10F)        return "R4";
        if (c >= 9'h111 && c <= 9'h11F)        return "R5";
        if (c >= 9'h121 && c <= 9'h12F)        return "R6";
        if (c == 9'h130 || c == 9'h134 || c == 9'h138 || c == 9'h13C) return "R7";
        if (c == 9'h140 || c == 9'h141)        return "R8";
        if (c == 9'h142 || c == 9'h143)        return "R9";
        return "R12";
    endfunction

    // expected value of one lane, written from the requirement text
    function automatic logic [DW-1:0] exp_lane(int n, logic [8:0] c, output bit ill);
        int s = n;
        int k = n % 16;
        int r = n / 16;
        int a = int'(c[3:0]);
        bit oob = 0;
        ill = 0;
        if (c <= 9'h0FF)                          s = (n / 4) * 4 + int'((c >> (2 * (n % 4))) & 9'd3);
        else if (c >= 9'h101 && c <= 9'h10F)      begin oob = (k + a > 15); s = r * 16 + k + a; end
        else if (c >= 9'h111 && c <= 9'h11F)      begin oob = (k - a < 0);  s = r * 16 + k - a; end
        else if (c >= 9'h121 && c <= 9'h12F)      s = r * 16 + (k - a + 16) % 16;
        else if (c == 9'h130)                     begin oob = (n == 63); s = n + 1; end
        else if (c == 9'h134)                     s = (n + 1) % 64;
        else if (c == 9'h138)                     begin oob = (n == 0); s = n - 1; end
        else if (c == 9'h13C)                     s = (n + 63) % 64;
        else if (c == 9'h140)                     s = r * 16 + 15 - k;
        else if (c == 9'h141)                     s = r * 16 + (k & 8) + 7 - (k & 7);
        else if (c == 9'h142)                     begin oob = (n < 16); s = (n & 'h30) - 1; end
        else if (c == 9'h143)                     begin oob = (n < 32); s = 31; end
        else                                      ill = 1;
        if (ill) return old_vec[n*DW +: DW];
        if (!row_mask[r] || !bank_mask[n % 4]) return old_vec[n*DW +: DW];
        if (oob || !exec_mask[s]) return bound_zero ? '0 : old_vec[n*DW +: DW];
        return src_vec[s*DW +: DW];
    endfunction

    task automatic check(string req, string what, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drives one request, samples the one-cycle result and the drain cycle
    task automatic run_one(logic [81:0] e, string req);
        logic [VEC_W-1:0] expv;
        bit ill_any = 0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        {perm_ctrl, row_mask, bank_mask, bound_zero, exec_mask} = e;
        for (int n = 0; n < LANES; n++) begin
            bit ill;
            expv[n*DW +: DW] = exp_lane(n, e[81:73], ill);
            ill_any = ill;
        end
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "out_valid after accept", VEC_W'(out_valid), VEC_W'(1'b1));
        check("R2", "in_ready low while valid", VEC_W'(in_ready), VEC_W'(1'b0));
        check(req, $sformatf("vector ctrl=%h", e[81:73]), out_vec, expv);
        check(req, "illegal flag", VEC_W'(out_illegal), VEC_W'(ill_any));
        @(negedge clk);
        check("R2", "single pulse", VEC_W'(out_valid), VEC_W'(1'b0));
        check("R2", "ready after drain", VEC_W'(in_ready), VEC_W'(1'b1));
    endtask

    initial begin
        for (int n = 0; n < LANES; n++) begin
            src_vec[n*DW +: DW] = 8'h40 + 8'(n);
            old_vec[n*DW +: DW] = 8'h80 + 8'(n);
        end
        repeat (3) @(negedge clk);
        // R1: state while held in reset
        check("R1", "out_valid in reset", VEC_W'(out_valid), '0);
        check("R1", "in_ready in reset", VEC_W'(in_ready), VEC_W'(1'b1));
        check("R1", "out_vec in reset", out_vec, '0);
        check("R1", "out_illegal in reset", VEC_W'(out_illegal), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", VEC_W'(out_valid), '0);

        for (int i = 0; i < NVEC; i++) run_one(TBL[i], req_of(TBL[i]));

        // directed literal checks
        run_one({9'h101, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF}, "R4");
        check("R4", "lane0 reads lane1", VEC_W'(out_vec[0 +: DW]), VEC_W'(8'h41));
        check("R11", "lane15 zero filled", VEC_W'(out_vec[15*DW +: DW]), '0);
        run_one({9'h142, 4'hF, 4'hF, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, "R9");
        check("R9", "lane48 reads lane47", VEC_W'(out_vec[48*DW +: DW]), VEC_W'(8'h6F));
        check("R9", "lane3 keeps old", VEC_W'(out_vec[3*DW +: DW]), VEC_W'(8'h83));
        run_one({9'h13C, 4'hF, 4'hF, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, "R7");
        check("R7", "lane0 wraps to lane63", VEC_W'(out_vec[0 +: DW]), VEC_W'(8'h7F));
        run_one({9'h100, 4'hF, 4'hF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF}, "R12");
        check("R12", "reserved flagged", VEC_W'(out_illegal), VEC_W'(1'b1));
        check("R12", "reserved keeps old", out_vec, old_vec);

        // R2: request held high across the busy cycle is taken only once
        @(negedge clk);
        perm_ctrl = 9'h0E4; in_valid = 1'b1;
        @(negedge clk);
        check("R2", "held request busy", VEC_W'({out_valid, in_ready}), VEC_W'(2'b10));
        @(negedge clk);
        check("R2", "held request re-accepted", VEC_W'({out_valid, in_ready}), VEC_W'(2'b01));
        in_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule